// File: doc/BRIEF.md
# PLL Divider Setting Calculator

This block works out the settings for a phase-locked loop whose VCO has a fixed lowest frequency. It takes a wanted output frequency and a reference frequency, both as unsigned integers in Hz. It returns three results:

- a power-of-two post-divider exponent Q;
- a feedback divider code F;
- the output frequency those two settings actually give.

The wanted frequency is first clamped to the range the loop can produce. The block then chooses the smallest post-divider that lifts the VCO to its minimum. The feedback code is the VCO-to-reference ratio rounded to the nearest integer, less one. A built-in restoring divider produces that ratio one quotient bit per cycle.

A second mode works the other way. It takes feedback and post-divider fields already in use, plus an external-bypass flag, and computes the output frequency they produce. Operands are presented with a single-cycle `start`. `busy` covers the work, and a one-cycle `done` marks the moment the registered results become valid.

Top module: `pll_ratio_calc`

## Requirements
- R1: In calculate mode (`mode_rb`=0) the wanted rate is clamped to the range from VCO_MIN/64 up to VCO_MIN (VCO_MIN = 2,133,000,000 Hz) before any other step.
- R2: In calculate mode `post_q` is the smallest value in 1..6 for which the clamped rate shifted left by that value reaches at least VCO_MIN; if none qualifies it is 6.
- R3: In calculate mode `fb_f` is ((clamped << Q) + ref/2) / ref − 1, using integer division. The result saturates to 0 when the quotient is 0 and to 255 when the value exceeds 8 bits.
- R4: In calculate mode `rate_out` is (ref × (`fb_f` + 1)) >> `post_q`.
- R5: In readback mode (`mode_rb`=1) `fb_f` and `post_q` echo `rb_fb` and `rb_post`. `rate_out` is `ref_rate` when `rb_bypass` is 1, and (ref × (`rb_fb` + 1)) >> `rb_post` otherwise, with `rb_post` allowed to be 0.
- R6: In calculate mode a `ref_rate` of 0 gives `err`=1 with `post_q`, `fb_f` and `rate_out` all 0. Any error-free completion clears `err`.
- R7: After an accepted `start`, `busy` is 1 from the next cycle until the cycle before `done`. `done` is high for exactly one cycle, and `done` and `busy` are never high together.
- R8: A `start` while `busy` is 1 is ignored; the results are those of the operands accepted first.
- R9: After reset `busy`, `done` and `err` are 0, and `post_q`, `fb_f` and `rate_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| mode_rb | input | 1 | 0 = calculate settings, 1 = readback of existing fields |
| req_rate | input | RATE_W | Wanted output frequency in Hz (calculate mode) |
| ref_rate | input | RATE_W | Reference / parent frequency in Hz |
| rb_fb | input | F_W | Existing feedback field (readback mode) |
| rb_post | input | Q_W | Existing post-divider exponent (readback mode) |
| rb_bypass | input | 1 | Existing external-bypass flag (readback mode) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| err | output | 1 | Zero reference in calculate mode |
| post_q | output | Q_W | Post-divider exponent |
| fb_f | output | F_W | Feedback divider code |
| rate_out | output | DP_W | Achieved / recomputed output frequency in Hz |

## Verification
Several properties are checked on every cycle:

- the handshake rules, meaning the single-cycle `done`, the exclusion of `done` and `busy`, and a `busy` that only starts after `start`;
- the Q range on every calculate completion;
- all-zero results whenever `err` is set;
- the pass-through of the reference frequency under bypass;
- the restoring divider's remainder staying below its divisor.

The arithmetic values are shown only by the bench's scenarios, each compared with a model written from the requirements. These values are the clamp boundaries, the exact Q threshold, rounding of F and its saturation at both ends, and the readback results with Q of 0. The bench also sends a second start in the middle of a calculation to show it is ignored.

// File: rtl/pll_calc_pkg.sv
`timescale 1ns/1ps
package pll_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_DIV,
    ST_EVAL,
    ST_FAIL
  } calc_state_e;

  typedef enum logic {
    MODE_CALC = 1'b0,
    MODE_READ = 1'b1
  } calc_mode_e;

endpackage

// File: rtl/pll_post_sel.sv
`timescale 1ns/1ps
// Clamps the wanted rate and picks the smallest post-divider exponent that
// lifts the VCO to its minimum.
module pll_post_sel #(
  parameter int              RATE_W     = 32,
  parameter int              DP_W       = 41,
  parameter int              Q_W        = 3,
  parameter int              Q_MIN      = 1,
  parameter int              Q_MAX      = 6,
  parameter longint unsigned VCO_MIN_HZ = 64'd2133000000
) (
  input  logic [RATE_W-1:0] req_i,
  output logic [RATE_W-1:0] clamped_o,
  output logic [Q_W-1:0]    q_o
);

  localparam logic [RATE_W-1:0] RATE_LO = RATE_W'(VCO_MIN_HZ >> Q_MAX);
  localparam logic [RATE_W-1:0] RATE_HI = RATE_W'(VCO_MIN_HZ);
  localparam logic [DP_W-1:0]   VCO_V   = DP_W'(VCO_MIN_HZ);

  logic [DP_W-1:0]        wide;
  logic [Q_MAX:Q_MIN]     reach;

  always_comb begin
    if (req_i < RATE_LO)      clamped_o = RATE_LO;
    else if (req_i > RATE_HI) clamped_o = RATE_HI;
    else                      clamped_o = req_i;
  end

  assign wide = DP_W'(clamped_o);

  for (genvar k = Q_MIN; k <= Q_MAX; k++) begin : g_cand
    assign reach[k] = (wide << k) >= VCO_V;
  end

  always_comb begin
    q_o = Q_W'(Q_MAX);
    for (int k = Q_MAX; k >= Q_MIN; k--) begin
      if (reach[k]) q_o = Q_W'(k);
    end
  end

endmodule

// File: rtl/pll_div_restoring.sv
`timescale 1ns/1ps
// Restoring shift-subtract divider, one quotient bit per cycle.
module pll_div_restoring #(
  parameter int W = 41
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     dvd_q;
  logic [W-1:0]     rem_q;
  logic [W-1:0]     dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial;
  logic             fits;

  assign trial = {rem_q, dvd_q[W-1]};
  assign fits  = trial >= {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !busy_o) begin
        dvd_q  <= dividend_i;
        dsr_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (fits) begin
          rem_q <= W'(trial - {1'b0, dsr_q});
          dvd_q <= {dvd_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          dvd_q <= {dvd_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = dvd_q;

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (rem_q < dsr_q));

  // R7
  div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/pll_rate_eval.sv
`timescale 1ns/1ps
// Output rate from reference, feedback code and post-divider exponent.
module pll_rate_eval #(
  parameter int RATE_W = 32,
  parameter int F_W    = 8,
  parameter int Q_W    = 3,
  parameter int DP_W   = 41
) (
  input  logic [RATE_W-1:0] ref_i,
  input  logic [F_W-1:0]    fb_i,
  input  logic [Q_W-1:0]    q_i,
  output logic [DP_W-1:0]   rate_o
);

  logic [F_W:0]    mult;
  logic [DP_W-1:0] prod;

  assign mult   = (F_W+1)'(fb_i) + 1'b1;
  assign prod   = DP_W'(ref_i) * DP_W'(mult);
  assign rate_o = prod >> q_i;

endmodule

// File: rtl/pll_ratio_calc.sv
`timescale 1ns/1ps
module pll_ratio_calc #(
  parameter int              RATE_W     = 32,
  parameter int              F_W        = 8,
  parameter int              Q_W        = 3,
  parameter int              Q_MIN      = 1,
  parameter int              Q_MAX      = 6,
  parameter longint unsigned VCO_MIN_HZ = 64'd2133000000,
  parameter int              DP_W       = RATE_W + F_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_rb,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [RATE_W-1:0] ref_rate,
  input  logic [F_W-1:0]    rb_fb,
  input  logic [Q_W-1:0]    rb_post,
  input  logic              rb_bypass,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [Q_W-1:0]    post_q,
  output logic [F_W-1:0]    fb_f,
  output logic [DP_W-1:0]   rate_out
);
  import pll_calc_pkg::*;

  localparam logic [DP_W-1:0] F_MAX = DP_W'((1 << F_W) - 1);

  calc_state_e       state_q;
  calc_mode_e        mode_q;
  logic [RATE_W-1:0] ref_q;
  logic [Q_W-1:0]    q_q;
  logic [F_W-1:0]    f_q;
  logic [DP_W-1:0]   num_q;
  logic              byp_q;

  logic [RATE_W-1:0] sel_rate;
  logic [Q_W-1:0]    sel_q;
  logic [DP_W-1:0]   vco;
  logic [DP_W-1:0]   num_next;
  logic              div_go;
  logic              div_busy;
  logic              div_done;
  logic [DP_W-1:0]   div_quot;
  logic [DP_W-1:0]   quot_m1;
  logic [F_W-1:0]    f_sat;
  logic [DP_W-1:0]   eval_rate;

  pll_post_sel #(
    .RATE_W(RATE_W), .DP_W(DP_W), .Q_W(Q_W),
    .Q_MIN(Q_MIN), .Q_MAX(Q_MAX), .VCO_MIN_HZ(VCO_MIN_HZ)
  ) u_sel (
    .req_i    (req_rate),
    .clamped_o(sel_rate),
    .q_o      (sel_q)
  );

  assign vco      = DP_W'(sel_rate) << sel_q;
  assign num_next = vco + DP_W'(ref_rate >> 1);
  assign div_go   = (state_q == ST_KICK);

  pll_div_restoring #(.W(DP_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .go_i      (div_go),
    .dividend_i(num_q),
    .divisor_i (DP_W'(ref_q)),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quot_o    (div_quot)
  );

  // Rounded quotient minus one, held inside the feedback field.
  always_comb begin
    quot_m1 = div_quot - 1'b1;
    if (div_quot == '0)        f_sat = '0;
    else if (quot_m1 > F_MAX)  f_sat = '1;
    else                       f_sat = quot_m1[F_W-1:0];
  end

  pll_rate_eval #(
    .RATE_W(RATE_W), .F_W(F_W), .Q_W(Q_W), .DP_W(DP_W)
  ) u_eval (
    .ref_i (ref_q),
    .fb_i  (f_q),
    .q_i   (q_q),
    .rate_o(eval_rate)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_CALC;
      ref_q    <= '0;
      q_q      <= '0;
      f_q      <= '0;
      num_q    <= '0;
      byp_q    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      post_q   <= '0;
      fb_f     <= '0;
      rate_out <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ref_q  <= ref_rate;
            mode_q <= calc_mode_e'(mode_rb);
            if (mode_rb) begin
              f_q     <= rb_fb;
              q_q     <= rb_post;
              byp_q   <= rb_bypass;
              state_q <= ST_EVAL;
            end else begin
              q_q     <= sel_q;
              num_q   <= num_next;
              byp_q   <= 1'b0;
              state_q <= (ref_rate == '0) ? ST_FAIL : ST_KICK;
            end
          end
        end
        ST_KICK: state_q <= ST_DIV;
        ST_DIV: begin
          if (div_done) begin
            f_q     <= f_sat;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          rate_out <= byp_q ? DP_W'(ref_q) : eval_rate;
          post_q   <= q_q;
          fb_f     <= f_q;
          err      <= 1'b0;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_FAIL: begin
          rate_out <= '0;
          post_q   <= '0;
          fb_f     <= '0;
          err      <= 1'b1;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R2
  q_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err && mode_q == MODE_CALC) |->
      (post_q >= Q_W'(Q_MIN) && post_q <= Q_W'(Q_MAX)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (rate_out == '0 && fb_f == '0 && post_q == '0));

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == MODE_READ && byp_q) |-> (rate_out == DP_W'(ref_q)));

  // R3
  div_owner_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> (state_q == ST_DIV));

endmodule

// File: tb/pll_ratio_calc_test.sv
`timescale 1ns/1ps
module pll_ratio_calc_test;

  localparam int RATE_W = 32;
  localparam int F_W    = 8;
  localparam int Q_W    = 3;
  localparam int DP_W   = RATE_W + F_W + 1;
  localparam longint unsigned VCO = 64'd2133000000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              mode_rb = 1'b0;
  logic [RATE_W-1:0] req_rate = '0;
  logic [RATE_W-1:0] ref_rate = '0;
  logic [F_W-1:0]    rb_fb = '0;
  logic [Q_W-1:0]    rb_post = '0;
  logic              rb_bypass = 1'b0;
  logic              busy, done, err;
  logic [Q_W-1:0]    post_q;
  logic [F_W-1:0]    fb_f;
  logic [DP_W-1:0]   rate_out;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pll_ratio_calc uut (
    .clk(clk), .rst(rst), .start(start), .mode_rb(mode_rb),
    .req_rate(req_rate), .ref_rate(ref_rate), .rb_fb(rb_fb),
    .rb_post(rb_post), .rb_bypass(rb_bypass), .busy(busy), .done(done),
    .err(err), .post_q(post_q), .fb_f(fb_f), .rate_out(rate_out)
  );

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model written from R1..R4.
  task automatic model(input longint unsigned req, input longint unsigned rf,
                       output longint unsigned q, output longint unsigned f,
                       output longint unsigned r);
    longint unsigned c, quot;
    c = req;
    if (c < (VCO >> 6)) c = VCO >> 6;
    if (c > VCO) c = VCO;
    q = 6;
    for (int k = 6; k >= 1; k--) if ((c << k) >= VCO) q = k;
    quot = ((c << q) + rf / 2) / rf;
    if (quot == 0) f = 0;
    else if (quot - 1 > 255) f = 255;
    else f = quot - 1;
    r = (rf * (f + 1)) >> q;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, "done seen", done, 1);
    check("R7", "busy low with done", busy, 0);
    @(negedge clk);
    check("R7", "done single cycle", done, 0);
  endtask

  task automatic run_calc(input string req, input longint unsigned rq,
                          input longint unsigned rf);
    longint unsigned eq, ef, er;
    model(rq, rf, eq, ef, er);
    mode_rb  = 1'b0;
    req_rate = RATE_W'(rq);
    ref_rate = RATE_W'(rf);
    pulse_start();
    check("R7", "busy after start", busy, 1);
    wait_done(req);
    check(req, "post_q", post_q, eq);
    check(req, "fb_f", fb_f, ef);
    check(req, "rate_out", rate_out, er);
    check(req, "err clear", err, 0);
  endtask

  task automatic run_read(input string req, input longint unsigned rf,
                          input int fb, input int pq, input bit byp);
    longint unsigned er;
    er = byp ? rf : ((rf * longint'(fb + 1)) >> pq);
    mode_rb   = 1'b1;
    ref_rate  = RATE_W'(rf);
    rb_fb     = F_W'(fb);
    rb_post   = Q_W'(pq);
    rb_bypass = byp;
    pulse_start();
    wait_done(req);
    check(req, "rb rate_out", rate_out, er);
    check(req, "rb fb echo", fb_f, longint'(fb));
    check(req, "rb q echo", post_q, longint'(pq));
  endtask

  task automatic test_reset();
    check("R9", "busy", busy, 0);
    check("R9", "done", done, 0);
    check("R9", "err", err, 0);
    check("R9", "rate_out", rate_out, 0);
    check("R9", "fb_f", fb_f, 0);
  endtask

  task automatic test_zero_ref();
    mode_rb  = 1'b0;
    req_rate = 32'd1000000000;
    ref_rate = '0;
    pulse_start();
    wait_done("R6");
    check("R6", "err", err, 1);
    check("R6", "rate zero", rate_out, 0);
    check("R6", "fb zero", fb_f, 0);
    check("R6", "q zero", post_q, 0);
  endtask

  task automatic test_ignore_start();
    longint unsigned eq, ef, er;
    model(64'd1000000000, 64'd25000000, eq, ef, er);
    mode_rb  = 1'b0;
    req_rate = 32'd1000000000;
    ref_rate = 32'd25000000;
    pulse_start();
    repeat (5) @(negedge clk);
    req_rate = 32'd50000000;
    ref_rate = 32'd1000000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8");
    check("R8", "rate kept", rate_out, er);
    check("R8", "fb kept", fb_f, ef);
    repeat (3) @(negedge clk);
    check("R8", "no second run", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_calc("R4", 64'd1000000000, 64'd25000000);
    run_calc("R1", 64'd1000, 64'd25000000);
    run_calc("R1", 64'd4000000000, 64'd25000000);
    run_calc("R2", 64'd1066500000, 64'd25000000);
    run_calc("R2", 64'd1066499999, 64'd25000000);
    run_calc("R3", 64'd1000000000, 64'd1000000);
    run_calc("R3", 64'd1000, 64'd4290000000);
    run_calc("R3", 64'd300000000, 64'd27000000);
    run_calc("R4", 64'd148500000, 64'd33333333);
    test_zero_ref();
    run_calc("R6", 64'd500000000, 64'd25000000);
    run_read("R5", 64'd100000000, 77, 3, 1'b1);
    run_read("R5", 64'd25000000, 159, 2, 1'b0);
    run_read("R5", 64'd25000000, 3, 0, 1'b0);
    run_read("R5", 64'd4294967295, 255, 7, 1'b0);
    test_ignore_start();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule